// File: doc/BRIEF.md
# Base-and-Bound Address Relocation Unit

This block sits between a user process and the memory system. Each logical address the process issues is compared against a bound register; when it lies below that bound the unit adds a relocation base and sends the resulting physical address to memory. An address at or above the bound is not forwarded. Instead the unit raises a protection trap for one cycle, so the process can reach only its own region of physical memory.

The base and bound are loaded through a small configuration port. That port takes a write only while the privilege input says the processor is in kernel mode. A write made from user mode changes nothing and raises a one-cycle privilege-fault flag. Translation passes through one register stage, with valid/ready handshakes on the request side and on the memory side.

Both registers clear to zero on reset. With a bound of zero, every user access traps until kernel code has configured the unit.

Top module: `reloc_unit`

## Requirements
- R1: After a synchronous reset, base and bound are zero, `mem_valid`, `trap` and `priv_fault` are low, and `req_ready` is high. The first request after reset therefore traps.
- R2: A logical address is legal exactly when its value is strictly below the bound. An address equal to the bound is illegal.
- R3: For a legal request accepted in cycle N, `mem_valid` is high in cycle N+1 with `mem_paddr` equal to base plus the zero-extended logical address, modulo 2^PA_W.
- R4: For an illegal request accepted in cycle N, `trap` is high in cycle N+1 only, and `mem_valid` stays low for that request.
- R5: A write with `kernel_mode` high loads base when `cfg_sel` is 0 and loads the bound when `cfg_sel` is 1 (bound taken from `cfg_wdata[LA_W:0]`). A request accepted in the same cycle as the write uses the old values; later requests use the new ones.
- R6: A write with `kernel_mode` low leaves base and bound unchanged, and raises `priv_fault` in the following cycle for one cycle.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid` and `mem_paddr` hold and `req_ready` is low. `req_ready` equals `!mem_valid || mem_ready`.
- R8: A bound of 2^LA_W makes every logical address legal, including the all-ones address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kernel_mode | input | 1 | High when the processor runs privileged code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 bound |
| cfg_wdata | input | PA_W | Configuration write data |
| priv_fault | output | 1 | One-cycle pulse after a user-mode write attempt |
| req_valid | input | 1 | Logical request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_laddr | input | LA_W | Logical address from the process |
| mem_valid | output | 1 | Physical request valid |
| mem_ready | input | 1 | Memory accepts the physical request |
| mem_paddr | output | PA_W | Relocated physical address |
| trap | output | 1 | One-cycle protection-trap pulse |

## Verification
The assertions check the following on every cycle:
- holding of the memory-side output under backpressure;
- that a trap never coincides with a forwarded request and always follows an accepted request;
- the relocation sum for each request just accepted;
- that user-mode writes leave both registers untouched and are answered by a privilege fault.

Only the bench's scenarios show the following:
- that the bound comparison is strict at its edge;
- that the all-legal bound and address wrap-around behave as stated;
- the ordering between a configuration write and a request accepted in the same cycle;
- that a rejected write leaves the old relocation visible through later translations.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_BOUND = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs #(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kernel_mode,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic [PA_W-1:0] base_q,
  output logic [LA_W:0]   bound_q,
  output logic            priv_fault
);
  import reloc_pkg::*;

  localparam int BOUND_W = LA_W + 1;

  cfg_sel_e sel;
  logic     wr_ok;
  logic     wr_bad;

  assign sel    = cfg_sel_e'(cfg_sel);
  assign wr_ok  = cfg_we && kernel_mode;
  assign wr_bad = cfg_we && !kernel_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      bound_q    <= '0;
      priv_fault <= 1'b0;
    end else begin
      priv_fault <= wr_bad;
      if (wr_ok) begin
        if (sel == SEL_BASE) base_q  <= cfg_wdata;
        else                 bound_q <= cfg_wdata[BOUND_W-1:0];
      end
    end
  end
endmodule

// File: rtl/reloc_bound_cmp.sv
module reloc_bound_cmp #(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic [LA_W-1:0] laddr,
  input  logic [LA_W:0]   bound,
  input  logic [PA_W-1:0] base,
  output logic            legal,
  output logic [PA_W-1:0] paddr
);
  localparam int PAD_W = PA_W - LA_W;

  logic [PA_W-1:0] laddr_ext;

  assign laddr_ext = {{PAD_W{1'b0}}, laddr};
  assign legal     = {1'b0, laddr} < bound;
  assign paddr     = base + laddr_ext;
endmodule

// File: rtl/reloc_xlate_stage.sv
module reloc_xlate_stage #(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            legal,
  input  logic [PA_W-1:0] paddr_in,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [PA_W-1:0] mem_paddr,
  output logic            trap
);
  logic accept;

  assign req_ready = !mem_valid || mem_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_paddr <= '0;
      trap      <= 1'b0;
    end else begin
      trap <= accept && !legal;
      if (accept) begin
        mem_valid <= legal;
        if (legal) mem_paddr <= paddr_in;
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kernel_mode,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic            priv_fault,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [LA_W-1:0] req_laddr,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [PA_W-1:0] mem_paddr,
  output logic            trap
);
  logic [PA_W-1:0] cur_base;
  logic [LA_W:0]   cur_bound;
  logic            is_legal;
  logic [PA_W-1:0] reloc_addr;

  reloc_cfg_regs #(.LA_W(LA_W), .PA_W(PA_W)) u_cfg (
    .clk(clk), .rst(rst), .kernel_mode(kernel_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_q(cur_base), .bound_q(cur_bound), .priv_fault(priv_fault)
  );

  reloc_bound_cmp #(.LA_W(LA_W), .PA_W(PA_W)) u_cmp (
    .laddr(req_laddr), .bound(cur_bound), .base(cur_base),
    .legal(is_legal), .paddr(reloc_addr)
  );

  reloc_xlate_stage #(.PA_W(PA_W)) u_stage (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .legal(is_legal), .paddr_in(reloc_addr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_paddr(mem_paddr), .trap(trap)
  );
endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            kernel_mode,
  input logic            cfg_we,
  input logic            priv_fault,
  input logic            req_valid,
  input logic            req_ready,
  input logic [LA_W-1:0] req_laddr,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic [PA_W-1:0] mem_paddr,
  input logic            trap,
  input logic [PA_W-1:0] cur_base,
  input logic [LA_W:0]   cur_bound
);
  logic            seen;
  logic [PA_W-1:0] laddr_ext;

  assign laddr_ext = {{(PA_W-LA_W){1'b0}}, req_laddr};

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!mem_valid && !trap && !priv_fault && cur_bound == '0));

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_paddr)));

  // R4
  trap_excl_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    trap |-> (!mem_valid && $past(req_valid && req_ready)));

  // R3
  reloc_sum_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    (mem_valid && $past(req_valid && req_ready)) |->
      (mem_paddr == $past(cur_base) + $past(laddr_ext)));

  // R2
  legal_fwd_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    (mem_valid && $past(req_valid && req_ready)) |->
      ({1'b0, $past(req_laddr)} < $past(cur_bound)));

  // R6
  user_write_blocked_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    $past(cfg_we && !kernel_mode) |->
      ($stable(cur_base) && $stable(cur_bound) && priv_fault));

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst || !seen)
    priv_fault |-> $past(cfg_we && !kernel_mode));
endmodule

bind reloc_unit reloc_unit_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .kernel_mode(kernel_mode), .cfg_we(cfg_we),
  .priv_fault(priv_fault), .req_valid(req_valid), .req_ready(req_ready),
  .req_laddr(req_laddr), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_paddr(mem_paddr), .trap(trap), .cur_base(cur_base), .cur_bound(cur_bound)
);

// File: tb/reloc_unit_test.sv
module reloc_unit_test;
  localparam int LA_W = 16;
  localparam int PA_W = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            kernel_mode = 1'b1;
  logic            cfg_we = 1'b0;
  logic            cfg_sel = 1'b0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic            priv_fault;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [LA_W-1:0] req_laddr = '0;
  logic            mem_valid;
  logic            mem_ready = 1'b1;
  logic [PA_W-1:0] mem_paddr;
  logic            trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic kern, input logic sel, input logic [PA_W-1:0] d,
                           input string req);
    @(negedge clk);
    kernel_mode = kern; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    chk(req, priv_fault, !kern);
    @(negedge clk);
    cfg_we = 1'b0; kernel_mode = 1'b0;
    @(posedge clk); #1;
    chk(req, priv_fault, 0);
  endtask

  task automatic xlate(input logic [LA_W-1:0] a, input bit exp_ok,
                       input logic [PA_W-1:0] exp_pa, input string req);
    @(negedge clk);
    mem_ready = 1'b1; req_valid = 1'b1; req_laddr = a;
    @(posedge clk); #1;
    chk(req, mem_valid, exp_ok);
    chk(req, trap, !exp_ok);
    if (exp_ok) chk(req, mem_paddr, exp_pa);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(req, trap, 0);
    chk(req, mem_valid, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", mem_valid, 0);
    chk("R1", trap, 0);
    chk("R1", priv_fault, 0);
    chk("R1", req_ready, 1);
    xlate(16'h0000, 0, '0, "R1");
  endtask

  task automatic t_basic();
    cfg_write(1, 0, 20'h01000, "R5");
    cfg_write(1, 1, 20'h00800, "R5");
    xlate(16'h0100, 1, 20'h01100, "R3");
    xlate(16'h07FF, 1, 20'h017FF, "R2");
    xlate(16'h0800, 0, '0, "R2");
    xlate(16'hFFFF, 0, '0, "R4");
  endtask

  task automatic t_user_write();
    cfg_write(0, 0, 20'h55555, "R6");
    cfg_write(0, 1, 20'h0FFFF, "R6");
    xlate(16'h0010, 1, 20'h01010, "R6");
    xlate(16'h0800, 0, '0, "R6");
  endtask

  task automatic t_full_bound();
    cfg_write(1, 0, 20'hFFFF0, "R5");
    cfg_write(1, 1, 20'h10000, "R8");
    xlate(16'hFFFF, 1, 20'h0FFEF, "R8");
    xlate(16'h0000, 1, 20'hFFFF0, "R3");
  endtask

  task automatic t_stall();
    @(negedge clk);
    mem_ready = 1'b0; req_valid = 1'b1; req_laddr = 16'h0020;
    @(posedge clk); #1;
    chk("R7", mem_valid, 1);
    chk("R7", mem_paddr, 20'h00010);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R7", mem_valid, 1);
      chk("R7", mem_paddr, 20'h00010);
      chk("R7", req_ready, 0);
    end
    @(negedge clk);
    mem_ready = 1'b1;
    #1 chk("R7", req_ready, 1);
    @(posedge clk); #1;
    chk("R7", mem_valid, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    kernel_mode = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = '0;
    mem_ready = 1'b1; req_valid = 1'b1; req_laddr = 16'h0004;
    @(posedge clk); #1;
    chk("R5", mem_valid, 1);
    chk("R5", mem_paddr, 20'hFFFF4);
    @(negedge clk);
    cfg_we = 1'b0; kernel_mode = 1'b0; req_valid = 1'b0;
    xlate(16'h0000, 0, '0, "R5");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_user_write();
    t_full_bound();
    t_stall();
    t_same_cycle();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule